// File: doc/BRIEF.md
# Dual Parity-Split Warp Issue Scheduler

This block decides, every cycle, which warp of a compute core may hand its next instruction to an execution pipeline. The warps are divided into two halves by the lowest bit of the warp ID. Each half has its own issue port and its own pipeline, and runs with no knowledge of the other half. Within a half, every warp is in one of three states: ready to issue, blocked because its next instruction is not yet buffered (a control hazard after a branch or call), or blocked because its next instruction depends on a result still in flight (a data hazard).

Each half offers one ready warp on a valid/ready port and picks it in round-robin order, starting just after the last warp that was accepted. A small scoreboard per warp records the destination registers of the instructions it has issued. A writeback event for that warp and register removes the entry. An instruction is 32 threads wide but a pipeline has 16 lanes, so after every acceptance a half rests for one cycle. A cycle in which a half could have handed over an instruction but did not is flagged as a bubble.

Back-pressure rules on each issue port: `iss_valid` never depends on `iss_ready`; once an offer is raised, the offered warp ID stays unchanged until a clock edge sees ready high. The environment keeps an offered warp's instruction-buffer inputs steady until it is accepted, and writeback port h only carries warps whose ID has low bit h.

Top module: `dual_warp_sched`

## Requirements
- R1: A warp whose ID g is even is only ever offered on port 0, and an odd ID only on port 1; the low bit of `iss_wid` on port h is always h, and the local index inside a half is g>>1.
- R2: The halves do not affect each other: a half with no ready warp or with ready held low does not delay offers or acceptances on the other half, and both halves may accept in the same cycle.
- R3: Each warp holds exactly one of three states (ready, control hazard, data hazard); a warp whose `ibuf_vld` bit is low is in the control-hazard state and is never offered.
- R4: A half searches its ready warps in increasing local index, wrapping, starting at the local index after the last accepted warp; after reset the search starts at local index 0.
- R5: A warp is in the data-hazard state, and not offered, while either source register of its next instruction, or its destination register when `ibuf_wr` is 1, equals a register pending in its scoreboard.
- R6: Accepting an instruction with `ibuf_wr`=1 makes its destination pending; the entry stays until the writeback port of that half carries the same warp ID and register; a writeback naming a register that is not pending changes nothing; a writeback and an acceptance for the same warp in one cycle both take effect.
- R7: An instruction with `ibuf_wr`=1 is held back while its warp already has SB_DEPTH pending registers.
- R8: When an offer is not accepted, the next cycle shows the same offer: `iss_valid` stays high and `iss_wid` is unchanged.
- R9: In the cycle after an acceptance a half makes no offer and reports no bubble, so a half accepts at most once in two cycles.
- R10: `iss_bubble` is high in every cycle that does not follow an acceptance and in which no acceptance takes place.
- R11: Reset puts every warp in the control-hazard state; no offer appears until an `ibuf_vld` bit has been seen high at a clock edge. An accepted warp spends the following cycle in the data-hazard state if it wrote a register, else in the control-hazard state.
- R12: Warp states are registered: a change on the instruction-buffer inputs or a writeback event alters the offers from the cycle after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ibuf_vld | input | NUM_WARPS | Per warp: next instruction is buffered |
| ibuf_wr | input | NUM_WARPS | Per warp: next instruction writes a register |
| ibuf_dst | input | NUM_WARPS*REG_W | Per warp: destination register of next instruction |
| ibuf_src0 | input | NUM_WARPS*REG_W | Per warp: first source register |
| ibuf_src1 | input | NUM_WARPS*REG_W | Per warp: second source register |
| wb_vld | input | 2 | Per half: writeback event present |
| wb_wid | input | 2*WID_W | Per half: warp ID of the writeback |
| wb_reg | input | 2*REG_W | Per half: register written back |
| iss_ready | input | 2 | Per half: pipeline accepts an instruction |
| iss_valid | output | 2 | Per half: a warp is offered |
| iss_wid | output | 2*WID_W | Per half: offered warp ID |
| iss_bubble | output | 2 | Per half: issue slot wasted this cycle |

## Verification
The two functions that can collide are a writeback that frees a scoreboard entry and an acceptance that fills one, both for the same warp in the same cycle. The bench builds three pending registers, holds the warp's next writer on the port with ready low, and then drives the writeback of one register together with ready high. The result is judged at the port afterwards: an instruction sourcing the freed register must issue, while one sourcing the newly recorded destination must stay blocked until its own writeback arrives.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

  typedef enum logic [1:0] {
    WS_READY = 2'd0,
    WS_CTRL  = 2'd1,
    WS_DATA  = 2'd2
  } warp_state_e;

endpackage

// File: rtl/warp_scoreboard.sv
module warp_scoreboard #(
  parameter int DEPTH = 4,
  parameter int REG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [REG_W-1:0] alloc_reg,
  input  logic             wb_en,
  input  logic [REG_W-1:0] wb_reg,
  input  logic             chk_wr,
  input  logic [REG_W-1:0] chk_dst,
  input  logic [REG_W-1:0] chk_src0,
  input  logic [REG_W-1:0] chk_src1,
  output logic             hazard
);

  localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] used_q;
  logic [DEPTH-1:0] drop;
  logic [DEPTH-1:0] live;
  logic [REG_W-1:0] reg_q [DEPTH];
  logic [SW-1:0]    slot;
  logic             slot_ok;
  logic             hit;

  // entries still pending once this cycle's writeback is applied
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      drop[i] = wb_en && used_q[i] && (reg_q[i] == wb_reg);
    end
    live = used_q & ~drop;
  end

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (live[i] && ((reg_q[i] == chk_src0) || (reg_q[i] == chk_src1) ||
                      (chk_wr && (reg_q[i] == chk_dst)))) begin
        hit = 1'b1;
      end
    end
  end

  always_comb begin
    slot    = '0;
    slot_ok = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!live[i] && !slot_ok) begin
        slot    = SW'(i);
        slot_ok = 1'b1;
      end
    end
  end

  assign hazard = hit || (chk_wr && !slot_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q <= '0;
      for (int i = 0; i < DEPTH; i++) reg_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        used_q[i] <= live[i] || (alloc && slot_ok && (slot == SW'(i)));
        if (alloc && slot_ok && (slot == SW'(i))) reg_q[i] <= alloc_reg;
      end
    end
  end

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  elig,
  input  logic [IW-1:0] start,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(start) + k) % N;
      if (!any && elig[j]) begin
        any = 1'b1;
        idx = IW'(j);
      end
    end
  end

endmodule

// File: rtl/warp_half_sched.sv
module warp_half_sched
  import wsched_pkg::*;
#(
  parameter int NW       = 16,
  parameter int SB_DEPTH = 4,
  parameter int REG_W    = 6,
  parameter int IW       = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NW-1:0]       ibuf_vld,
  input  logic [NW-1:0]       ibuf_wr,
  input  logic [NW*REG_W-1:0] ibuf_dst,
  input  logic [NW*REG_W-1:0] ibuf_src0,
  input  logic [NW*REG_W-1:0] ibuf_src1,
  input  logic                wb_en,
  input  logic [IW-1:0]       wb_idx,
  input  logic [REG_W-1:0]    wb_reg,
  input  logic                iss_ready,
  output logic                iss_valid,
  output logic [IW-1:0]       iss_idx,
  output logic                iss_bubble
);

  logic [NW-1:0] elig;
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] pick_idx;
  logic          pick_any;
  logic          hold_q;
  logic [IW-1:0] hold_idx_q;
  logic          rest_q;
  logic          take;

  rr_pick #(.N(NW), .IW(IW)) u_pick (
    .elig  (elig),
    .start (ptr_q),
    .any   (pick_any),
    .idx   (pick_idx)
  );

  assign iss_valid  = !rest_q && (hold_q || pick_any);
  assign iss_idx    = hold_q ? hold_idx_q : pick_idx;
  assign take       = iss_valid && iss_ready;
  assign iss_bubble = !rest_q && !take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
      rest_q     <= 1'b0;
    end else begin
      rest_q <= take;
      hold_q <= iss_valid && !iss_ready;
      if (iss_valid && !iss_ready) hold_idx_q <= iss_idx;
      if (take) ptr_q <= (iss_idx == IW'(NW - 1)) ? '0 : iss_idx + 1'b1;
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_warp
    warp_state_e st_q;
    logic        haz;
    logic        mine;
    logic        wb_mine;

    assign mine    = take && (iss_idx == IW'(w));
    assign wb_mine = wb_en && (wb_idx == IW'(w));
    assign elig[w] = (st_q == WS_READY);

    warp_scoreboard #(.DEPTH(SB_DEPTH), .REG_W(REG_W)) u_sb (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc     (mine && ibuf_wr[w]),
      .alloc_reg (ibuf_dst[w*REG_W +: REG_W]),
      .wb_en     (wb_mine),
      .wb_reg    (wb_reg),
      .chk_wr    (ibuf_wr[w]),
      .chk_dst   (ibuf_dst[w*REG_W +: REG_W]),
      .chk_src0  (ibuf_src0[w*REG_W +: REG_W]),
      .chk_src1  (ibuf_src1[w*REG_W +: REG_W]),
      .hazard    (haz)
    );

    always_ff @(posedge clk) begin
      if (!rst_n)            st_q <= WS_CTRL;
      else if (mine)         st_q <= ibuf_wr[w] ? WS_DATA : WS_CTRL;
      else if (!ibuf_vld[w]) st_q <= WS_CTRL;
      else if (haz)          st_q <= WS_DATA;
      else                   st_q <= WS_READY;
    end
  end

endmodule

// File: rtl/dual_warp_sched.sv
module dual_warp_sched #(
  parameter int NUM_WARPS = 32,
  parameter int SB_DEPTH  = 4,
  parameter int REG_W     = 6,
  parameter int WID_W     = $clog2(NUM_WARPS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_WARPS-1:0]       ibuf_vld,
  input  logic [NUM_WARPS-1:0]       ibuf_wr,
  input  logic [NUM_WARPS*REG_W-1:0] ibuf_dst,
  input  logic [NUM_WARPS*REG_W-1:0] ibuf_src0,
  input  logic [NUM_WARPS*REG_W-1:0] ibuf_src1,
  input  logic [1:0]                 wb_vld,
  input  logic [2*WID_W-1:0]         wb_wid,
  input  logic [2*REG_W-1:0]         wb_reg,
  input  logic [1:0]                 iss_ready,
  output logic [1:0]                 iss_valid,
  output logic [2*WID_W-1:0]         iss_wid,
  output logic [1:0]                 iss_bubble
);

  localparam int HALF  = NUM_WARPS / 2;
  localparam int LID_W = WID_W - 1;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF-1:0]       vld_l;
    logic [HALF-1:0]       wr_l;
    logic [HALF*REG_W-1:0] dst_l;
    logic [HALF*REG_W-1:0] s0_l;
    logic [HALF*REG_W-1:0] s1_l;
    logic [LID_W-1:0]      lidx;

    for (genvar w = 0; w < HALF; w++) begin : g_map
      assign vld_l[w]                 = ibuf_vld[2*w + h];
      assign wr_l[w]                  = ibuf_wr[2*w + h];
      assign dst_l[w*REG_W +: REG_W]  = ibuf_dst[(2*w + h)*REG_W +: REG_W];
      assign s0_l[w*REG_W +: REG_W]   = ibuf_src0[(2*w + h)*REG_W +: REG_W];
      assign s1_l[w*REG_W +: REG_W]   = ibuf_src1[(2*w + h)*REG_W +: REG_W];
    end

    warp_half_sched #(
      .NW(HALF), .SB_DEPTH(SB_DEPTH), .REG_W(REG_W), .IW(LID_W)
    ) u_half (
      .clk        (clk),
      .rst_n      (rst_n),
      .ibuf_vld   (vld_l),
      .ibuf_wr    (wr_l),
      .ibuf_dst   (dst_l),
      .ibuf_src0  (s0_l),
      .ibuf_src1  (s1_l),
      .wb_en      (wb_vld[h]),
      .wb_idx     (wb_wid[h*WID_W + 1 +: LID_W]),
      .wb_reg     (wb_reg[h*REG_W +: REG_W]),
      .iss_ready  (iss_ready[h]),
      .iss_valid  (iss_valid[h]),
      .iss_idx    (lidx),
      .iss_bubble (iss_bubble[h])
    );

    assign iss_wid[h*WID_W +: WID_W] = {lidx, 1'(h)};
  end

endmodule

// File: rtl/dual_warp_sched_chk.sv
module dual_warp_sched_chk #(
  parameter int NUM_WARPS = 32,
  parameter int WID_W     = $clog2(NUM_WARPS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_WARPS-1:0] ibuf_vld,
  input logic [1:0]           wb_vld,
  input logic [2*WID_W-1:0]   wb_wid,
  input logic [1:0]           iss_ready,
  input logic [1:0]           iss_valid,
  input logic [2*WID_W-1:0]   iss_wid,
  input logic [1:0]           iss_bubble
);

  for (genvar h = 0; h < 2; h++) begin : g_chk
    AST_PARITY_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[h] |-> (iss_wid[h*WID_W] == 1'(h))); // R1
    AST_WB_PORT_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      wb_vld[h] |-> (wb_wid[h*WID_W] == 1'(h))); // R6
    AST_NO_CTRL_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[h] |-> ibuf_vld[iss_wid[h*WID_W +: WID_W]]); // R3
    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid[h] && !iss_ready[h]) |=>
        (iss_valid[h] && $stable(iss_wid[h*WID_W +: WID_W]))); // R8
    AST_REST_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid[h] && iss_ready[h]) |=> (!iss_valid[h] && !iss_bubble[h])); // R9
    AST_BUBBLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (!iss_valid[h] && !$past(iss_valid[h] && iss_ready[h])) |-> iss_bubble[h]); // R10
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> !iss_valid[h]); // R11
  end

endmodule

bind dual_warp_sched dual_warp_sched_chk #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ibuf_vld   (ibuf_vld),
  .wb_vld     (wb_vld),
  .wb_wid     (wb_wid),
  .iss_ready  (iss_ready),
  .iss_valid  (iss_valid),
  .iss_wid    (iss_wid),
  .iss_bubble (iss_bubble)
);

// File: tb/dual_warp_sched_bench.sv
`timescale 1ns/100ps
module dual_warp_sched_bench;

  localparam int NW = 8;
  localparam int RW = 4;
  localparam int WW = 3;
  localparam int HW = NW / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NW-1:0]    b_vld, b_wr;
  logic [RW-1:0]    b_dst [NW];
  logic [RW-1:0]    b_s0  [NW];
  logic [RW-1:0]    b_s1  [NW];
  logic [NW*RW-1:0] p_dst, p_s0, p_s1;
  logic [1:0]       wbv;
  logic [2*WW-1:0]  wbw;
  logic [2*RW-1:0]  wbr;
  logic [1:0]       rdy;
  logic [1:0]       iss_valid, iss_bubble;
  logic [2*WW-1:0]  iss_wid;

  always_comb begin
    for (int g = 0; g < NW; g++) begin
      p_dst[g*RW +: RW] = b_dst[g];
      p_s0[g*RW +: RW]  = b_s0[g];
      p_s1[g*RW +: RW]  = b_s1[g];
    end
  end

  dual_warp_sched #(.NUM_WARPS(NW), .SB_DEPTH(4), .REG_W(RW)) u_dual_warp_sched (
    .clk(clk), .rst_n(rst_n), .ibuf_vld(b_vld), .ibuf_wr(b_wr),
    .ibuf_dst(p_dst), .ibuf_src0(p_s0), .ibuf_src1(p_s1),
    .wb_vld(wbv), .wb_wid(wbw), .wb_reg(wbr), .iss_ready(rdy),
    .iss_valid(iss_valid), .iss_wid(iss_wid), .iss_bubble(iss_bubble)
  );

  int n_chk = 0;
  int n_fail = 0;
  int n_hs [2];
  logic [HW-1:0] msk [2];
  int  mptr [2];
  bit  sweep_on = 1'b0;
  bit  prev_hs [2];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  function automatic int next_set(input logic [HW-1:0] m, input int p);
    for (int k = 0; k < HW; k++) begin
      if (m[(p + k) % HW]) return (p + k) % HW;
    end
    return -1;
  endfunction

  task automatic set_ins(input int g, input bit v, input bit w,
                         input int d, input int a, input int b);
    b_vld[g] = v; b_wr[g] = w;
    b_dst[g] = RW'(d); b_s0[g] = RW'(a); b_s1[g] = RW'(b);
  endtask

  task automatic wait_issue(input int h, input int exp_wid, input string req);
    for (int i = 0; i < 20; i++) begin
      if (iss_valid[h] && rdy[h]) begin
        chk(int'(iss_wid[h*WW +: WW]) == exp_wid, req, "accepted warp",
            int'(iss_wid[h*WW +: WW]), exp_wid);
        tick();
        return;
      end
      tick();
    end
    chk(1'b0, req, "no acceptance before timeout", 0, 1);
  endtask

  task automatic quiet(input int h, input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      chk(!iss_valid[h], req, "warp offered while blocked", int'(iss_valid[h]), 0);
      tick();
    end
  endtask

  // port monitor: rest cycle, bubble flag, parity, round-robin order
  always begin
    @(negedge clk);
    #1.5;
    if (!rst_n) begin
      prev_hs[0] = 1'b0; prev_hs[1] = 1'b0;
      mptr[0] = 0; mptr[1] = 0;
    end else begin
      for (int h = 0; h < 2; h++) begin
        bit hs_now;
        int wid;
        hs_now = iss_valid[h] && rdy[h];
        wid = int'(iss_wid[h*WW +: WW]);
        if (prev_hs[h])
          chk(!iss_valid[h] && !iss_bubble[h], "R9", "rest cycle after acceptance",
              int'({iss_valid[h], iss_bubble[h]}), 0);
        else
          chk(iss_bubble[h] == !hs_now, "R10", "bubble flag",
              int'(iss_bubble[h]), int'(!hs_now));
        if (hs_now) begin
          n_hs[h]++;
          chk(wid % 2 == h, "R1", "warp parity on port", wid % 2, h);
          if (sweep_on) begin
            int e;
            e = next_set(msk[h], mptr[h]);
            chk(wid / 2 == e, "R4", "round-robin local index", wid / 2, e);
            mptr[h] = (e + 1) % HW;
          end
        end
        prev_hs[h] = hs_now;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    b_vld = '0; b_wr = '0;
    for (int g = 0; g < NW; g++) set_ins(g, 0, 0, 0, 0, 0);
    wbv = '0; wbw = '0; wbr = '0; rdy = 2'b11;
    n_hs[0] = 0; n_hs[1] = 0;
    msk[0] = '0; msk[1] = '0;

    repeat (3) tick();
    chk(iss_valid == 2'b00, "R11", "offer during reset", int'(iss_valid), 0);
    rst_n = 1'b1;
    tick(); tick();
    chk(iss_valid == 2'b00, "R11", "offer with empty buffers", int'(iss_valid), 0);
    chk(iss_bubble == 2'b11, "R10", "bubble with no ready warp", int'(iss_bubble), 3);

    // all masks: half 0 takes m, half 1 its complement (R3, R4)
    for (int m = 0; m < (1 << HW); m++) begin
      rst_n = 1'b0;
      msk[0] = HW'(m);
      msk[1] = ~HW'(m);
      for (int g = 0; g < NW; g++) set_ins(g, msk[g % 2][g / 2], 0, 0, 0, 0);
      tick(); tick();
      n_hs[0] = 0; n_hs[1] = 0;
      rst_n = 1'b1;
      sweep_on = 1'b1;
      repeat (24) tick();
      sweep_on = 1'b0;
      for (int h = 0; h < 2; h++) begin
        if (msk[h] == '0) chk(n_hs[h] == 0, "R3", "issues with no buffered warp", n_hs[h], 0);
        else              chk(n_hs[h] >= 10, "R4", "issues in sweep window", n_hs[h], 10);
      end
    end

    rst_n = 1'b0;
    b_vld = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();

    // data hazard on warp 0 (R5, R6, R12)
    set_ins(0, 1, 1, 5, 0, 0);
    wait_issue(0, 0, "R6");
    set_ins(0, 1, 0, 0, 5, 0);
    quiet(0, 5, "R5");
    wbv[0] = 1'b1; wbw[0 +: WW] = 3'd0; wbr[0 +: RW] = 4'd7;
    tick();
    wbv[0] = 1'b0;
    quiet(0, 3, "R6");
    wbv[0] = 1'b1; wbr[0 +: RW] = 4'd5;
    chk(!iss_valid[0], "R12", "offer before writeback is sampled", int'(iss_valid[0]), 0);
    tick();
    wbv[0] = 1'b0;
    chk(iss_valid[0] && iss_wid[0 +: WW] == 3'd0, "R12", "offer one cycle after writeback",
        int'(iss_valid[0]), 1);
    wait_issue(0, 0, "R5");
    b_vld[0] = 1'b0;

    // scoreboard on warp 2, warp 1 streams on the other half
    set_ins(1, 1, 0, 0, 0, 0);
    for (int d = 1; d <= 3; d++) begin
      set_ins(2, 1, 1, d, 0, 0);
      wait_issue(0, 2, "R6");
    end
    begin
      int base;
      base = n_hs[1];
      rdy[0] = 1'b0;
      set_ins(2, 1, 1, 4, 8, 9);
      tick();
      for (int i = 0; i < 3; i++) begin
        chk(iss_valid[0] && iss_wid[0 +: WW] == 3'd2, "R8", "held offer",
            int'(iss_wid[0 +: WW]), 2);
        chk(iss_bubble[0], "R10", "bubble while held", int'(iss_bubble[0]), 1);
        tick();
      end
      // writeback of reg 1 and acceptance of writer to reg 4 together
      chk(iss_valid[0], "R8", "offer still up", int'(iss_valid[0]), 1);
      wbv[0] = 1'b1; wbw[0 +: WW] = 3'd2; wbr[0 +: RW] = 4'd1;
      rdy[0] = 1'b1;
      tick();
      wbv[0] = 1'b0;
      set_ins(2, 1, 0, 0, 4, 0);
      quiet(0, 5, "R6");
      chk(n_hs[1] - base >= 3, "R2", "other half kept issuing", n_hs[1] - base, 3);
    end
    wbv[0] = 1'b1; wbr[0 +: RW] = 4'd4;
    tick();
    wbv[0] = 1'b0;
    wait_issue(0, 2, "R6");
    set_ins(2, 1, 0, 0, 1, 0);
    wait_issue(0, 2, "R6");
    set_ins(2, 1, 1, 6, 0, 0);
    wait_issue(0, 2, "R6");
    set_ins(2, 1, 1, 7, 0, 0);
    wait_issue(0, 2, "R6");
    set_ins(2, 1, 1, 12, 13, 14);
    quiet(0, 5, "R7");
    wbv[0] = 1'b1; wbr[0 +: RW] = 4'd6;
    tick();
    wbv[0] = 1'b0;
    wait_issue(0, 2, "R7");
    set_ins(2, 1, 1, 3, 0, 0);
    quiet(0, 5, "R5");
    wbv[0] = 1'b1; wbr[0 +: RW] = 4'd3;
    tick();
    wbv[0] = 1'b0;
    wait_issue(0, 2, "R5");
    b_vld = '0;
    repeat (4) tick();
    chk(iss_valid == 2'b00, "R3", "offer after buffers emptied", int'(iss_valid), 0);
    finish_run();
  end

endmodule